// File: doc/BRIEF.md
# Bit-Serial Sine and Cosine Engine

This block turns a 16-bit angle into its sine and cosine with the circular rotation form of the CORDIC method. All arithmetic is bit-serial. Each of the three running values (the x and y coordinates and the residual angle z) has one single-bit adder/subtractor with a carry flip-flop. A rotation step streams one word through those adders, least significant bit first, so one step costs one word-time of clocks and not one clock. The right shift by the step index does not use a barrel shifter. A multiplexer reads the other coordinate at a higher bit position, and once that position passes the top of the word it keeps reading the sign bit.

The host interface is a word-wide handshake. The host pulses `start` with an angle on `angleIn`. The block loads its working registers in parallel, runs a fixed number of rotation steps and copies the coordinates into parallel output registers. It then pulses `done`. The arctangent step constants are held in a small on-chip table. The x register starts at the reciprocal of the rotation gain, so no scaling is needed afterwards.

Top module: `serialCordic`

## Requirements
- R1: During and right after reset, `busy` and `done` are low and `sinOut` and `cosOut` are zero.
- R2: A `start` high at a rising edge while `busy` is low begins a computation. `busy` is high from the next cycle until `done` rises.
- R3: `done` is high for exactly one cycle, at the ITERS*16+1-th rising edge after the edge that accepted `start` (257 with the default of 16 steps). `busy` is low in that same cycle.
- R4: `angleIn` is 16-bit two's complement, with +/-32768 standing for +/-pi. `sinOut` and `cosOut` are two's complement Q1.14, so 16384 means 1.0. The results equal this integer recurrence bit for bit. Start with x=9949 (16384 divided by the product of sqrt(1+2^-2i) over all steps, rounded), y=0 and z=angle. In step i, if z>=0 then x-=y>>>i, y+=x>>>i and z-=a[i]. Otherwise x+=y>>>i, y-=x>>>i and z+=a[i]. Both updates use the old x and y, `>>>` is an arithmetic (flooring) shift, and a[i]=round(atan(2^-i)*32768/pi). At the end cos=x and sin=y.
- R5: For any angle from -16384 to +16384 (+/-pi/2), each output is within 32 LSB of 16384 times the true sine or cosine.
- R6: A `start` pulse while `busy` is high is ignored. The running computation finishes at its original time with the result of its original angle.
- R7: `sinOut` and `cosOut` change only at the edge where `done` rises. They hold their values through the next computation until it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation (sampled while idle) |
| angleIn | input | 16 | Angle, two's complement, +/-32768 = +/-pi |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| sinOut | output | 16 | Sine result, Q1.14 |
| cosOut | output | 16 | Cosine result, Q1.14 |

## Verification
The bench sweeps the angle across the full +/-pi/2 span in steps of 256 and adds the two end points, zero and a few odd values. Each result is compared bit for bit against an integer model of the recurrence and, within 32 LSB, against a real sine and cosine. A design that taps the shifted operand at the wrong position, fails to sign-extend once the tap passes the top bit, or gets the subtract carry preset wrong would produce results that drift off the exact model, usually by large amounts near +/-pi/2. A second `start` is injected mid-run: a design that restarts would raise `done` late with the new angle's result. Outputs are also checked in the middle of a later run, where a design that leaks working registers to the ports would show partial values.

// File: rtl/cordicSerialPkg.sv
package cordicSerialPkg;

  localparam int DATA_W    = 16;
  localparam int MAX_ITERS = 16;
  localparam int BIT_W     = $clog2(DATA_W);
  localparam int ITER_W    = $clog2(MAX_ITERS);

  // 1/gain for 16 steps in Q1.14
  localparam logic [DATA_W-1:0] X_INIT = DATA_W'(9949);

  typedef struct packed {
    logic              load;
    logic              step;
    logic              firstBit;
    logic              lastBit;
    logic              capture;
    logic [BIT_W-1:0]  bitIdx;
    logic [ITER_W-1:0] iterIdx;
  } ctrlStrobes_t;

  // atan(2^-i) scaled so that pi maps to 2^(DATA_W-1)
  function automatic logic [DATA_W-1:0] atanConst(input logic [ITER_W-1:0] idx);
    logic [DATA_W-1:0] v;
    case (idx)
      4'd0:    v = DATA_W'(8192);
      4'd1:    v = DATA_W'(4836);
      4'd2:    v = DATA_W'(2555);
      4'd3:    v = DATA_W'(1297);
      4'd4:    v = DATA_W'(651);
      4'd5:    v = DATA_W'(326);
      4'd6:    v = DATA_W'(163);
      4'd7:    v = DATA_W'(81);
      4'd8:    v = DATA_W'(41);
      4'd9:    v = DATA_W'(20);
      4'd10:   v = DATA_W'(10);
      4'd11:   v = DATA_W'(5);
      4'd12:   v = DATA_W'(3);
      4'd13:   v = DATA_W'(1);
      4'd14:   v = DATA_W'(1);
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cordicSerialAddSub.sv
module cordicSerialAddSub (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic first,
  input  logic sub,
  input  logic aBit,
  input  logic bBit,
  output logic sumBit
);
  logic carryQ;
  logic bEff;
  logic carryIn;
  logic carryOut;

  always_comb begin
    bEff     = bBit ^ sub;
    carryIn  = first ? sub : carryQ;   // preset 1 for subtract at LSB
    sumBit   = aBit ^ bEff ^ carryIn;
    carryOut = (aBit & bEff) | (aBit & carryIn) | (bEff & carryIn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   carryQ <= 1'b0;
    else if (en) carryQ <= carryOut;
  end
endmodule

// File: rtl/cordicSerialCtrl.sv
module cordicSerialCtrl
  import cordicSerialPkg::*;
#(
  parameter int ITERS = MAX_ITERS
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output ctrlStrobes_t strobes
);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);
  localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(ITERS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_UNLOAD} ctrlState_t;

  ctrlState_t        state;
  logic [BIT_W-1:0]  bitCnt;
  logic [ITER_W-1:0] iterCnt;
  logic              doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      iterCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= (state == ST_UNLOAD);
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            bitCnt  <= '0;
            iterCnt <= '0;
          end
        end
        ST_RUN: begin
          if (bitCnt == LAST_BIT) begin
            bitCnt <= '0;
            if (iterCnt == LAST_ITER) begin
              iterCnt <= '0;
              state   <= ST_UNLOAD;
            end else begin
              iterCnt <= iterCnt + 1'b1;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_UNLOAD: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.load     = (state == ST_IDLE) && start;
    strobes.step     = (state == ST_RUN);
    strobes.firstBit = (bitCnt == '0);
    strobes.lastBit  = (bitCnt == LAST_BIT);
    strobes.capture  = (state == ST_UNLOAD);
    strobes.bitIdx   = bitCnt;
    strobes.iterIdx  = iterCnt;
    busy             = (state != ST_IDLE);
    done             = doneQ;
  end
endmodule

// File: rtl/cordicSerialDatapath.sv
module cordicSerialDatapath
  import cordicSerialPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] angleIn,
  output logic [DATA_W-1:0] sinOut,
  output logic [DATA_W-1:0] cosOut
);
  localparam int LANES = 3;  // 0: x, 1: y, 2: z

  logic [DATA_W-1:0] xCur, yCur, zCur;
  logic [DATA_W-2:0] xNxt, yNxt, zNxt;
  logic [DATA_W-1:0] atanWord;
  logic [BIT_W:0]    tapSum;
  logic [BIT_W-1:0]  tapIdx;
  logic              rotPos;
  logic [LANES-1:0]  aBits, bBits, subs, sums;

  always_comb begin
    tapSum   = {1'b0, strobes.bitIdx} + (BIT_W+1)'(strobes.iterIdx);
    tapIdx   = (tapSum >= (BIT_W+1)'(DATA_W)) ? BIT_W'(DATA_W - 1) : tapSum[BIT_W-1:0];
    atanWord = atanConst(strobes.iterIdx);
    rotPos   = ~zCur[DATA_W-1];

    aBits[0] = xCur[strobes.bitIdx];
    bBits[0] = yCur[tapIdx];
    subs[0]  = rotPos;

    aBits[1] = yCur[strobes.bitIdx];
    bBits[1] = xCur[tapIdx];
    subs[1]  = ~rotPos;

    aBits[2] = zCur[strobes.bitIdx];
    bBits[2] = atanWord[strobes.bitIdx];
    subs[2]  = rotPos;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    cordicSerialAddSub addSub_i (
      .clk    (clk),
      .rstN   (rstN),
      .en     (strobes.step),
      .first  (strobes.firstBit),
      .sub    (subs[g]),
      .aBit   (aBits[g]),
      .bBit   (bBits[g]),
      .sumBit (sums[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xCur   <= '0;
      yCur   <= '0;
      zCur   <= '0;
      xNxt   <= '0;
      yNxt   <= '0;
      zNxt   <= '0;
      sinOut <= '0;
      cosOut <= '0;
    end else begin
      if (strobes.load) begin
        xCur <= X_INIT;
        yCur <= '0;
        zCur <= angleIn;
      end else if (strobes.step) begin
        if (strobes.lastBit) begin
          xCur <= {sums[0], xNxt};
          yCur <= {sums[1], yNxt};
          zCur <= {sums[2], zNxt};
        end else begin
          xNxt <= {sums[0], xNxt[DATA_W-2:1]};
          yNxt <= {sums[1], yNxt[DATA_W-2:1]};
          zNxt <= {sums[2], zNxt[DATA_W-2:1]};
        end
      end
      if (strobes.capture) begin
        sinOut <= yCur;
        cosOut <= xCur;
      end
    end
  end
endmodule

// File: rtl/serialCordic.sv
module serialCordic
  import cordicSerialPkg::*;
#(
  parameter int ITERS = MAX_ITERS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] angleIn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] sinOut,
  output logic [DATA_W-1:0] cosOut
);
  ctrlStrobes_t strobes;

  cordicSerialCtrl #(.ITERS(ITERS)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .strobes (strobes)
  );

  cordicSerialDatapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .angleIn (angleIn),
    .sinOut  (sinOut),
    .cosOut  (cosOut)
  );
endmodule

// File: rtl/serialCordicChecker.sv
module serialCordicChecker
  import cordicSerialPkg::*;
#(
  parameter int ITERS = MAX_ITERS
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] sinOut,
  input logic [DATA_W-1:0] cosOut
);
  // sampled count when done is seen: accept edge counts 1, done edge adds ITERS*DATA_W+1
  localparam logic [15:0] DONE_COUNT = 16'(ITERS * DATA_W + 2);

  logic [15:0] cyclesSinceStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cyclesSinceStart <= '0;
    else if (start && !busy)  cyclesSinceStart <= 16'd1;
    else if (busy)            cyclesSinceStart <= cyclesSinceStart + 16'd1;
    else                      cyclesSinceStart <= '0;
  end

  AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);  // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R3

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cyclesSinceStart == DONE_COUNT));  // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(sinOut) && $stable(cosOut)));  // R7
endmodule

bind serialCordic serialCordicChecker #(.ITERS(ITERS)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .sinOut (sinOut),
  .cosOut (cosOut)
);

// File: tb/serialCordic_tb_top.sv
`timescale 1ns/1ps
module serialCordic_tb_top;
  localparam int STEPS = 16;
  localparam int LAT   = STEPS * 16 + 1;
  localparam real PI   = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] angleIn = '0;
  logic        busy, done;
  logic [15:0] sinOut, cosOut;

  int checks = 0;
  int errors = 0;
  int atanTab [STEPS];
  int xStart;
  int lastSin = 0;
  int lastCos = 0;

  always #4 clk = ~clk;

  serialCordic dut_i (
    .clk(clk), .rstN(rstN), .start(start), .angleIn(angleIn),
    .busy(busy), .done(done), .sinOut(sinOut), .cosOut(cosOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic refModel(input int ang, output int s, output int c);
    int x, y, z, xn, yn;
    x = xStart; y = 0; z = ang;
    for (int i = 0; i < STEPS; i++) begin
      if (z >= 0) begin
        xn = x - (y >>> i); yn = y + (x >>> i); z = z - atanTab[i];
      end else begin
        xn = x + (y >>> i); yn = y - (x >>> i); z = z + atanTab[i];
      end
      x = xn; y = yn;
    end
    s = y; c = x;
  endtask

  task automatic runOne(input int ang, input bit inject, input int other);
    int expS, expC, k, gotS, gotC;
    real idealS, idealC;
    bit seen;
    refModel(ang, expS, expC);
    @(negedge clk);
    start = 1'b1; angleIn = ang[15:0];
    @(negedge clk);
    start = 1'b0; angleIn = 16'h0000;
    k = 0; seen = 0;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    while (!seen && k < 2000) begin
      if (inject && k == 40) begin start = 1'b1; angleIn = other[15:0]; end
      if (inject && k == 41) start = 1'b0;
      if (k == 100) begin
        check(int'($signed(sinOut)) == lastSin, "R7 sin held mid-run", int'($signed(sinOut)), lastSin);
        check(int'($signed(cosOut)) == lastCos, "R7 cos held mid-run", int'($signed(cosOut)), lastCos);
      end
      if (done) seen = 1;
      else begin
        if (!busy) check(1'b0, "R2 busy dropped early", k, LAT);
        @(negedge clk);
        k++;
      end
    end
    check(k == LAT, inject ? "R6 latency with ignored start" : "R3 done latency", k, LAT);
    check(busy == 1'b0, "R3 busy low with done", int'(busy), 0);
    gotS = int'($signed(sinOut));
    gotC = int'($signed(cosOut));
    check(gotS == expS, inject ? "R6 sin of first angle" : "R4 sin exact", gotS, expS);
    check(gotC == expC, inject ? "R6 cos of first angle" : "R4 cos exact", gotC, expC);
    idealS = 16384.0 * $sin(real'(ang) * PI / 32768.0);
    idealC = 16384.0 * $cos(real'(ang) * PI / 32768.0);
    check((real'(gotS) - idealS <= 32.0) && (idealS - real'(gotS) <= 32.0),
          "R5 sin accuracy", gotS, $rtoi(idealS));
    check((real'(gotC) - idealC <= 32.0) && (idealC - real'(gotC) <= 32.0),
          "R5 cos accuracy", gotC, $rtoi(idealC));
    @(negedge clk);
    check(done == 1'b0, "R3 done one cycle", int'(done), 0);
    lastSin = gotS; lastCos = gotC;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog expired actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    real g;
    g = 1.0;
    for (int i = 0; i < STEPS; i++) begin
      atanTab[i] = $rtoi($atan(1.0 / real'(1 << i)) * 32768.0 / PI + 0.5);
      g = g * $sqrt(1.0 + 1.0 / real'(1 << (2 * i)));
    end
    xStart = $rtoi(16384.0 / g + 0.5);

    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(sinOut == 16'h0000, "R1 sin in reset", int'(sinOut), 0);
    check(cosOut == 16'h0000, "R1 cos in reset", int'(cosOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 idle after reset", int'({busy, done}), 0);

    for (int a = -16384; a <= 16384; a += 256) runOne(a, 1'b0, 0);
    runOne(0, 1'b0, 0);
    runOne(1, 1'b0, 0);
    runOne(-1, 1'b0, 0);
    runOne(12345, 1'b0, 0);
    runOne(-9999, 1'b0, 0);
    runOne(16383, 1'b0, 0);

    runOne(5000, 1'b1, -15000);
    runOne(-7000, 1'b1, 16000);

    repeat (30) @(negedge clk);
    check(int'($signed(sinOut)) == lastSin, "R7 sin held idle", int'($signed(sinOut)), lastSin);
    check(int'($signed(cosOut)) == lastCos, "R7 cos held idle", int'($signed(cosOut)), lastCos);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule